// File: doc/BRIEF.md
# Write Fault Emergency Detector

This block guards the write path of a multi-head storage drive. Every clock it samples the head-select lines, the active-low write-mode and erase-enable controls, and a digital flag that reports write or erase current in the heads. It looks for two unsafe situations. The first is more than one head selected while writing. The second is head current present while the drive is reading. If either is seen, the block latches an emergency state.

The latched state drives a not-ready request and a supply-cut request to the drive controller. Both requests rise one clock after the unsafe sample, which is well inside the one-microsecond budget for stopping write current. A 2-bit trip code records which condition caused the trip. Any edge of write mode or erase enable opens a masking window, and the current-in-read check is ignored while that window is open, so mode switching cannot raise a false alarm. The emergency state stays set until the controller asserts the clear input in a cycle where neither condition is present.

Top module: `write_fault_detector`

## Requirements
- R1: When write mode is active (`wr_mode_n` = 0) and two or more bits of `head_sel` are 1, `emerg` is 1 from the next clock on, and bit 0 of `trip_code` is 1.
- R2: A single selected head while writing, or any number of selected heads while write mode is inactive, causes no trip.
- R3: When `wr_mode_n` = 1, `erase_en_n` = 1, `cur_sense` = 1 and no mask window is open, `emerg` is 1 from the next clock on, and bit 1 of `trip_code` is 1.
- R4: `cur_sense` = 1 causes no trip while write mode or erase enable is active (either control at 0).
- R5: Any change of `wr_mode_n` or `erase_en_n` restarts a mask window that covers the sample with the change and the following MASK_CYC-1 samples. Inside the window the current-in-read check is suppressed. The first sample after the window can trip.
- R6: Once set, `emerg` and `trip_code` hold until `fault_clr` = 1 is sampled in a cycle with neither condition present. That sample returns both to 0.
- R7: `fault_clr` has no effect in a cycle where either condition is present.
- R8: While latched, the trip code accumulates: a new condition sets its own bit and never clears a bit that is already set, so the code can read 2'b11.
- R9: `not_ready_req` and `supply_cut_req` always equal `emerg`. An asserted `rst_n` forces all outputs to 0 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| head_sel | input | N_HEADS | One bit per head, 1 = selected |
| wr_mode_n | input | 1 | Write mode, active low |
| erase_en_n | input | 1 | Erase enable, active low |
| cur_sense | input | 1 | 1 = write or erase current flows in the heads |
| fault_clr | input | 1 | Request to clear the latched emergency |
| emerg | output | 1 | Latched emergency state |
| not_ready_req | output | 1 | Not-ready request to the controller |
| supply_cut_req | output | 1 | Request to interrupt the head current supply |
| trip_code | output | 2 | Latched cause: bit 0 multi-head write, bit 1 current in read |

## Verification
The hardest case to reach from the ports is the exact edge of the mask window. The bench has to show that current in read is ignored on the last masked sample and trips on the first unmasked one. It also has to show that a second mode edge restarts the window rather than extending the old one. The bench builds the block with a short window. It walks a vector table whose repeat counts land samples on both sides of the boundary. A directed test then toggles erase enable low for a single cycle and back, so that two edges fall one sample apart and the trip point reveals which edge the window counted from.

// File: rtl/wfd_pkg.sv
package wfd_pkg;
  localparam int TRIP_W    = 2;
  localparam int BIT_MULTI = 0;
  localparam int BIT_RDCUR = 1;
  typedef logic [TRIP_W-1:0] trip_t;
endpackage

// File: rtl/wfd_mode_mask.sv
module wfd_mode_mask #(
  parameter int MASK_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_mode_n,
  input  logic erase_en_n,
  output logic masked
);
  localparam int CW = $clog2(MASK_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(MASK_CYC - 1);

  logic          wm_q, ee_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          edge_c;

  always_comb begin
    edge_c = (wr_mode_n != wm_q) || (erase_en_n != ee_q);
    if (edge_c)           cnt_d = LOAD;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    else                  cnt_d = cnt_q;
    masked = edge_c || (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wm_q  <= 1'b1;
      ee_q  <= 1'b1;
      cnt_q <= '0;
    end else begin
      wm_q  <= wr_mode_n;
      ee_q  <= erase_en_n;
      cnt_q <= cnt_d;
    end
  end

  // R5: a mode edge seen at the ports opens the window
  p_edge_masks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(wr_mode_n) || $fell(wr_mode_n) || $rose(erase_en_n) || $fell(erase_en_n)) |-> masked);
endmodule

// File: rtl/wfd_cond.sv
module wfd_cond #(
  parameter int N_HEADS = 4
) (
  input  logic [N_HEADS-1:0] head_sel,
  input  logic               wr_mode_n,
  input  logic               erase_en_n,
  input  logic               cur_sense,
  input  logic               masked,
  output logic               multi_c,
  output logic               rdcur_c
);
  localparam int SW = $clog2(N_HEADS + 1);
  logic [SW-1:0] n_sel;
  logic          read_mode;

  always_comb begin
    n_sel = '0;
    for (int i = 0; i < N_HEADS; i++) n_sel = n_sel + SW'(head_sel[i]);
    read_mode = wr_mode_n && erase_en_n;
    multi_c   = !wr_mode_n && (n_sel >= SW'(2));
    rdcur_c   = read_mode && cur_sense && !masked;
  end
endmodule

// File: rtl/wfd_trip_latch.sv
module wfd_trip_latch
  import wfd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  multi_c,
  input  logic  rdcur_c,
  input  logic  fault_clr,
  output logic  emerg_q,
  output trip_t code_q
);
  logic  fault_c, emerg_d;
  trip_t code_d, hit_c;

  always_comb begin
    hit_c            = '0;
    hit_c[BIT_MULTI] = multi_c;
    hit_c[BIT_RDCUR] = rdcur_c;
    fault_c          = multi_c || rdcur_c;
    if (fault_c) begin
      emerg_d = 1'b1;
      code_d  = code_q | hit_c;
    end else if (fault_clr) begin
      emerg_d = 1'b0;
      code_d  = '0;
    end else begin
      emerg_d = emerg_q;
      code_d  = code_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      emerg_q <= 1'b0;
      code_q  <= '0;
    end else begin
      emerg_q <= emerg_d;
      code_q  <= code_d;
    end
  end

  p_trip_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    multi_c |=> (emerg_q && code_q[BIT_MULTI]));
  p_trip_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rdcur_c |=> (emerg_q && code_q[BIT_RDCUR]));
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (emerg_q && !fault_clr) |=> emerg_q);
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_clr && !multi_c && !rdcur_c) |=> (!emerg_q && code_q == '0));
  p_code_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (emerg_q && !fault_clr) |=> ((code_q & $past(code_q)) == $past(code_q)));
  p_code_needs_emerg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q != '0) |-> emerg_q);
endmodule

// File: rtl/write_fault_detector.sv
module write_fault_detector
  import wfd_pkg::*;
#(
  parameter int N_HEADS  = 4,
  parameter int MASK_CYC = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_HEADS-1:0] head_sel,
  input  logic               wr_mode_n,
  input  logic               erase_en_n,
  input  logic               cur_sense,
  input  logic               fault_clr,
  output logic               emerg,
  output logic               not_ready_req,
  output logic               supply_cut_req,
  output logic [TRIP_W-1:0]  trip_code
);
  logic  rst_s1, rst_sn;
  logic  masked, multi_c, rdcur_c, emerg_q;
  trip_t code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  wfd_mode_mask #(.MASK_CYC(MASK_CYC)) u_mask (
    .clk(clk), .rst_n(rst_sn), .wr_mode_n(wr_mode_n),
    .erase_en_n(erase_en_n), .masked(masked));

  wfd_cond #(.N_HEADS(N_HEADS)) u_cond (
    .head_sel(head_sel), .wr_mode_n(wr_mode_n), .erase_en_n(erase_en_n),
    .cur_sense(cur_sense), .masked(masked), .multi_c(multi_c), .rdcur_c(rdcur_c));

  wfd_trip_latch u_latch (
    .clk(clk), .rst_n(rst_sn), .multi_c(multi_c), .rdcur_c(rdcur_c),
    .fault_clr(fault_clr), .emerg_q(emerg_q), .code_q(code_q));

  always_comb begin
    emerg          = emerg_q;
    not_ready_req  = emerg_q;
    supply_cut_req = emerg_q;
    trip_code      = code_q;
  end

  // R4: current while writing or erasing, with at most one head, never trips
  p_write_cur_ok_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    ((!wr_mode_n || !erase_en_n) && ($countones(head_sel) < 2) && !emerg) |=> !emerg);
  // R2: no current and no write mode never trips, whatever the heads
  p_read_heads_ok_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr_mode_n && !cur_sense && !emerg) |=> !emerg);
endmodule

// File: tb/tb_write_fault_detector.sv
module tb_write_fault_detector;
  localparam int NH = 4;
  localparam int MC = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NH-1:0] head_sel;
  logic          wr_mode_n, erase_en_n, cur_sense, fault_clr;
  logic          emerg, not_ready_req, supply_cut_req;
  logic [1:0]    trip_code;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4ns clk = ~clk;

  write_fault_detector #(.N_HEADS(NH), .MASK_CYC(MC)) dut (
    .clk(clk), .rst_n(rst_n), .head_sel(head_sel), .wr_mode_n(wr_mode_n),
    .erase_en_n(erase_en_n), .cur_sense(cur_sense), .fault_clr(fault_clr),
    .emerg(emerg), .not_ready_req(not_ready_req), .supply_cut_req(supply_cut_req),
    .trip_code(trip_code));

  typedef struct packed {
    logic [3:0] hs;
    logic       wm, ee, cur, clr;
    logic [3:0] rep;
    logic       e;
    logic [1:0] code;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VEC [13] = '{
    '{4'b0000, 1'b1, 1'b1, 1'b0, 1'b0, 4'd1,  1'b0, 2'b00, 4'd9}, // R9 idle
    '{4'b0011, 1'b1, 1'b1, 1'b0, 1'b0, 4'd1,  1'b0, 2'b00, 4'd2}, // R2 heads in read
    '{4'b0001, 1'b0, 1'b0, 1'b1, 1'b0, 4'd1,  1'b0, 2'b00, 4'd4}, // R4 current in write
    '{4'b0100, 1'b0, 1'b0, 1'b1, 1'b0, 4'd4,  1'b0, 2'b00, 4'd2}, // R2 single head write
    '{4'b0101, 1'b0, 1'b0, 1'b1, 1'b0, 4'd1,  1'b1, 2'b01, 4'd1}, // R1 multi-head write
    '{4'b0001, 1'b0, 1'b0, 1'b1, 1'b1, 4'd1,  1'b0, 2'b00, 4'd6}, // R6 clear
    '{4'b0001, 1'b1, 1'b0, 1'b1, 1'b0, 4'd10, 1'b0, 2'b00, 4'd4}, // R4 erase only
    '{4'b0001, 1'b1, 1'b1, 1'b1, 1'b0, 4'd7,  1'b0, 2'b00, 4'd5}, // R5 inside window
    '{4'b0001, 1'b1, 1'b1, 1'b1, 1'b0, 4'd1,  1'b0, 2'b00, 4'd5}, // R5 last masked
    '{4'b0001, 1'b1, 1'b1, 1'b1, 1'b0, 4'd1,  1'b1, 2'b10, 4'd3}, // R3 trip after window
    '{4'b1001, 1'b0, 1'b1, 1'b1, 1'b1, 4'd1,  1'b1, 2'b11, 4'd7}, // R7 clear ignored, R8
    '{4'b0001, 1'b0, 1'b1, 1'b1, 1'b0, 4'd3,  1'b1, 2'b11, 4'd6}, // R6 held
    '{4'b0001, 1'b0, 1'b1, 1'b1, 1'b1, 4'd1,  1'b0, 2'b00, 4'd6}  // R6 clear works
  };

  task automatic check_out(input int req, input logic e_exp, input logic [1:0] c_exp);
    checks++;
    if (emerg !== e_exp || not_ready_req !== e_exp || supply_cut_req !== e_exp
        || trip_code !== c_exp) begin
      errors++;
      $display("FAIL R%0d: emerg=%b nr=%b sc=%b code=%b expected emerg=%b code=%b",
               req, emerg, not_ready_req, supply_cut_req, trip_code, e_exp, c_exp);
    end
  endtask

  task automatic drive(input logic [3:0] hs, input logic wm, input logic ee,
                       input logic cur, input logic clr, input int n);
    for (int k = 0; k < n; k++) begin
      head_sel = hs; wr_mode_n = wm; erase_en_n = ee; cur_sense = cur; fault_clr = clr;
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    head_sel = '0; wr_mode_n = 1'b1; erase_en_n = 1'b1; cur_sense = 1'b0; fault_clr = 1'b0;
    repeat (3) @(negedge clk);
    check_out(9, 1'b0, 2'b00); // R9 reset state
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < 13; i++) begin
      drive(VEC[i].hs, VEC[i].wm, VEC[i].ee, VEC[i].cur, VEC[i].clr, int'(VEC[i].rep));
      check_out(int'(VEC[i].req), VEC[i].e, VEC[i].code);
    end

    // R5: window restarts on the second edge of a one-cycle erase pulse
    drive(4'b0000, 1'b1, 1'b1, 1'b0, 1'b0, 12);
    check_out(5, 1'b0, 2'b00);
    drive(4'b0000, 1'b1, 1'b0, 1'b1, 1'b0, 1);
    drive(4'b0000, 1'b1, 1'b1, 1'b1, 1'b0, MC);
    check_out(5, 1'b0, 2'b00); // still masked, counted from the rising edge
    drive(4'b0000, 1'b1, 1'b1, 1'b1, 1'b0, 1);
    check_out(3, 1'b1, 2'b10); // R3 first unmasked sample trips

    // R9: reset clears a latched trip at once
    #1ns rst_n = 1'b0;
    #1ns check_out(9, 1'b0, 2'b00);
    cur_sense = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: multi-head write after reset, code bit 0 only
    drive(4'b1100, 1'b0, 1'b0, 1'b0, 1'b0, 1);
    check_out(1, 1'b1, 2'b01);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800us;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule